// File: doc/BRIEF.md
# Infrared Serial Port Signal Conditioner

This block sits between a UART and the pins of an infrared serial link. On the transmit side it can invert the UART's serial output. It can then gate that output with a carrier whose low time is selectable. A two-bit selector decides what drives the transmit pin: the conditioned UART data, a general-purpose output bit, or one of two metering pulse streams. The pin is driven from a register, so it never glitches.

On the receive side, the comparator result can be inverted on its way into the UART. A routing bit can instead hand the receive pin to general-purpose input use. While the pin is routed that way, the UART sees a steady idle level.

The carrier comes from a free-running 4-bit phase counter. The counter advances once every `CAR_DIV` clocks, so one carrier period is 16 × `CAR_DIV` clocks. All configuration inputs are expected to be held at 0 by their owner after reset. That default is an unmodulated, non-inverted UART path, with the receive pin attached to the UART.

Top module: `irport_cond`

## Requirements
- R1: `cfg_tx_src` selects the transmit pin source: 0 = UART path, 1 = `gpo_bit`, 2 = `wpulse`, 3 = `varpulse`.
- R2: With `cfg_tx_inv` = 1, the UART data is complemented before modulation, so inverted data that is 0 receives the carrier.
- R3: With `cfg_mod_en` = 1 and UART data (after inversion) at 1, `tx_pin` stays 1. When that data is 0, `tx_pin` follows the carrier.
- R4: With modulation active on data 0, `tx_pin` is low for 8, 4, 2 or 1 phase steps out of every 16, for `cfg_duty` = 0, 1, 2 or 3 respectively. Each phase step lasts `CAR_DIV` clocks.
- R5: `tx_pin` is registered: it reflects its inputs one clock edge after they are applied.
- R6: `cfg_rx_inv` = 1 complements `rx_cmp` on the way to `uart_rxd` only. It never alters `gpi_bit`.
- R7: With `cfg_rx_gpio` = 1, `gpi_bit` follows `rx_cmp` and `uart_rxd` is held at 1. With `cfg_rx_gpio` = 0, `gpi_bit` is 0 and `uart_rxd` comes from the comparator.
- R8: While `rst_n` is low at a clock edge, `tx_pin` becomes 1 after that edge.
- R9: Inversion and modulation act only on the UART source. Sources 1 to 3 reach `tx_pin` unaltered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_tx_src | input | 2 | Transmit pin source select |
| cfg_tx_inv | input | 1 | Invert UART transmit data |
| cfg_mod_en | input | 1 | Enable carrier modulation |
| cfg_duty | input | 2 | Carrier low-time code |
| cfg_rx_gpio | input | 1 | Route receive pin to general-purpose input |
| cfg_rx_inv | input | 1 | Invert comparator result into UART |
| uart_txd | input | 1 | UART serial output |
| gpo_bit | input | 1 | General-purpose output bit |
| wpulse | input | 1 | Real-energy pulse stream |
| varpulse | input | 1 | Reactive-energy pulse stream |
| rx_cmp | input | 1 | Receive comparator result |
| tx_pin | output | 1 | Transmit pin drive |
| uart_rxd | output | 1 | Serial input to UART |
| gpi_bit | output | 1 | General-purpose input bit |

## Verification
The bench builds the block with `CAR_DIV` = 2, which makes the prescaler count rather than pass every clock. A full carrier period is then only 32 clocks. Low time is counted over a window of exactly two carrier periods. That count does not depend on where the phase counter stands when the window opens, so all four duty codes can be measured without knowing the counter's position. A short period also allows inverted and non-inverted data, and the non-UART sources, to be run with modulation on, all within a brief run.

// File: rtl/irport_pkg.sv
// Shared types for the infrared port conditioner.
// Assumes a two-bit source code; the values are decoded by the transmit path.
package irport_pkg;
    typedef enum logic [1:0] {
        SRC_UART   = 2'd0,
        SRC_GPO    = 2'd1,
        SRC_WPULSE = 2'd2,
        SRC_VPULSE = 2'd3
    } tx_src_e;
endpackage

// File: rtl/irport_carrier.sv
// Carrier generator: a prescaler that divides clk by DIV, driving a PH_W-bit
// phase counter. The carrier is low for the first (2^(PH_W-1) >> duty) phase
// steps of every 2^PH_W. Assumes PH_W >= 4 so that duty code 3 still gives a
// low time of at least one step.
module irport_carrier #(
    parameter int DIV  = 4,
    parameter int PH_W = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] duty,
    output logic       carrier_hi
);
    localparam int                PRE_W    = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PRE_W-1:0]  PRE_LAST = PRE_W'(DIV - 1);
    localparam int                HALF     = 1 << (PH_W - 1);

    logic [PRE_W-1:0] pre_q;
    logic [PH_W-1:0]  phase_q;
    logic [PH_W-1:0]  low_cnt;
    logic             tick;

    assign tick = (pre_q == PRE_LAST);

    // Prescaler: wraps after DIV clocks, pulsing tick on its last count.
    always_ff @(posedge clk) begin
        if (!rst_n)    pre_q <= '0;
        else if (tick) pre_q <= '0;
        else           pre_q <= pre_q + PRE_W'(1);
    end

    // Phase counter: advances one step per prescaler tick, free-running.
    always_ff @(posedge clk) begin
        if (!rst_n)    phase_q <= '0;
        else if (tick) phase_q <= phase_q + PH_W'(1);
    end

    // Low-time threshold: half of the period, shifted right by the duty code.
    always_comb low_cnt = PH_W'(HALF >> duty);

    // Carrier level: low while the phase is below the threshold.
    always_comb carrier_hi = (phase_q >= low_cnt);

    // R4
    phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (phase_q == $past(phase_q) + PH_W'(1)));
    // R4
    phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(phase_q));
endmodule

// File: rtl/irport_tx.sv
// Transmit conditioner: inverts UART data, then optionally gates it with the
// carrier (carrier applied only while the data is 0), and selects the pin
// source. The pin is registered and resets to 1, the idle line level.
module irport_tx
    import irport_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] src,
    input  logic       tx_inv,
    input  logic       mod_en,
    input  logic       carrier_hi,
    input  logic       uart_txd,
    input  logic       gpo_bit,
    input  logic       wpulse,
    input  logic       varpulse,
    output logic       tx_pin
);
    logic data_pol;
    logic data_mod;
    logic pin_d;

    // Polarity stage: inversion comes before modulation.
    always_comb data_pol = uart_txd ^ tx_inv;

    // Modulation stage: carrier replaces the data only where the data is 0.
    always_comb data_mod = (mod_en && !data_pol) ? carrier_hi : data_pol;

    // Source multiplexer for the pin.
    always_comb begin
        unique case (tx_src_e'(src))
            SRC_UART:   pin_d = data_mod;
            SRC_GPO:    pin_d = gpo_bit;
            SRC_WPULSE: pin_d = wpulse;
            SRC_VPULSE: pin_d = varpulse;
            default:    pin_d = 1'b1;
        endcase
    end

    // Output register: glitch-free pin drive, idle high in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) tx_pin <= 1'b1;
        else        tx_pin <= pin_d;
    end

    // R8
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> tx_pin);
    // R3
    mark_unmod_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src == 2'd0 && (uart_txd ^ tx_inv)) |=> tx_pin);
    // R9
    gpo_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src == 2'd1) |=> (tx_pin == $past(gpo_bit)));
    // R1
    vpulse_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src == 2'd3) |=> (tx_pin == $past(varpulse)));
endmodule

// File: rtl/irport_rx.sv
// Receive router: sends the comparator result, optionally inverted, to the
// UART, or hands the raw result to general-purpose input use. While the pin is
// routed to general-purpose use, the UART sees the idle level 1.
module irport_rx (
    input  logic rx_cmp,
    input  logic rx_inv,
    input  logic rx_gpio,
    output logic uart_rxd,
    output logic gpi_bit
);
    // UART input: comparator with optional inversion, or idle when routed away.
    always_comb uart_rxd = rx_gpio ? 1'b1 : (rx_cmp ^ rx_inv);

    // General-purpose input: raw comparator, never inverted.
    always_comb gpi_bit = rx_gpio & rx_cmp;

    // R7 R6
    always_comb begin
        if (rx_gpio) begin
            gpi_follow_chk: assert (gpi_bit == rx_cmp && uart_rxd);
        end
    end
endmodule

// File: rtl/irport_cond.sv
// Top of the infrared port conditioner: carrier generator, transmit
// conditioner and receive router. Configuration inputs are assumed to be
// static or slowly changing, and owned by the surrounding register block.
module irport_cond #(
    parameter int CAR_DIV = 4,
    parameter int PH_W    = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] cfg_tx_src,
    input  logic       cfg_tx_inv,
    input  logic       cfg_mod_en,
    input  logic [1:0] cfg_duty,
    input  logic       cfg_rx_gpio,
    input  logic       cfg_rx_inv,
    input  logic       uart_txd,
    input  logic       gpo_bit,
    input  logic       wpulse,
    input  logic       varpulse,
    input  logic       rx_cmp,
    output logic       tx_pin,
    output logic       uart_rxd,
    output logic       gpi_bit
);
    logic carrier_hi;

    irport_carrier #(.DIV(CAR_DIV), .PH_W(PH_W)) u_carrier (
        .clk        (clk),
        .rst_n      (rst_n),
        .duty       (cfg_duty),
        .carrier_hi (carrier_hi)
    );

    irport_tx u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .src        (cfg_tx_src),
        .tx_inv     (cfg_tx_inv),
        .mod_en     (cfg_mod_en),
        .carrier_hi (carrier_hi),
        .uart_txd   (uart_txd),
        .gpo_bit    (gpo_bit),
        .wpulse     (wpulse),
        .varpulse   (varpulse),
        .tx_pin     (tx_pin)
    );

    irport_rx u_rx (
        .rx_cmp   (rx_cmp),
        .rx_inv   (cfg_rx_inv),
        .rx_gpio  (cfg_rx_gpio),
        .uart_rxd (uart_rxd),
        .gpi_bit  (gpi_bit)
    );

    // R6
    rx_uart_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rx_gpio |-> (uart_rxd == (rx_cmp ^ cfg_rx_inv)) && !gpi_bit);
endmodule

// File: tb/irport_cond_tb.sv
// Self-checking bench: a vector table for static routing, then directed tests
// for reset, pin latency, modulation duty and the non-UART sources.
module irport_cond_tb;
    localparam int DIV    = 2;
    localparam int PERIOD = 16 * DIV;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cfg_tx_src = '0;
    logic       cfg_tx_inv = 1'b0, cfg_mod_en = 1'b0;
    logic [1:0] cfg_duty = '0;
    logic       cfg_rx_gpio = 1'b0, cfg_rx_inv = 1'b0;
    logic       uart_txd = 1'b1, gpo_bit = 1'b0, wpulse = 1'b0, varpulse = 1'b0;
    logic       rx_cmp = 1'b0;
    logic       tx_pin, uart_rxd, gpi_bit;

    int checks = 0;
    int errors = 0;

    irport_cond #(.CAR_DIV(DIV)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_tx_src(cfg_tx_src), .cfg_tx_inv(cfg_tx_inv),
        .cfg_mod_en(cfg_mod_en), .cfg_duty(cfg_duty), .cfg_rx_gpio(cfg_rx_gpio),
        .cfg_rx_inv(cfg_rx_inv), .uart_txd(uart_txd), .gpo_bit(gpo_bit),
        .wpulse(wpulse), .varpulse(varpulse), .rx_cmp(rx_cmp),
        .tx_pin(tx_pin), .uart_rxd(uart_rxd), .gpi_bit(gpi_bit)
    );

    always #5 clk = ~clk;

    // Vector: {src[1:0], tx_inv, rx_gpio, rx_inv, utx, gpo, wp, vp, cmp, e_tx, e_urx, e_gpi}
    localparam int NV = 10;
    localparam logic [12:0] VEC [NV] = '{
        {2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},
        {2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        {2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
        {2'd0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        {2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1},
        {2'd1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
        {2'd2, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1},
        {2'd2, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
        {2'd3, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        {2'd3, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0}
    };

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic check_int(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Count low samples of tx_pin over two full carrier periods.
    task automatic count_low(output int lows);
        lows = 0;
        for (int i = 0; i < 2 * PERIOD; i++) begin
            @(negedge clk);
            if (!tx_pin) lows++;
        end
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int lows;
        // R8: reset drives the pin to idle high even with UART data at 0.
        uart_txd = 1'b0;
        repeat (3) @(negedge clk);
        check("R8 reset idle", tx_pin, 1'b1);
        rst_n = 1'b1;

        // R1 R2 R6 R7: static routing table, modulation off.
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            {cfg_tx_src, cfg_tx_inv, cfg_rx_gpio, cfg_rx_inv,
             uart_txd, gpo_bit, wpulse, varpulse, rx_cmp} = VEC[v][12:3];
            @(negedge clk);
            check("R1 R2 tx_pin", tx_pin, VEC[v][2]);
            check("R6 R7 uart_rxd", uart_rxd, VEC[v][1]);
            check("R7 gpi_bit", gpi_bit, VEC[v][0]);
        end

        // R5: the pin holds its value until the next clock edge.
        @(negedge clk);
        {cfg_tx_src, cfg_tx_inv, cfg_rx_gpio, cfg_rx_inv} = '0;
        uart_txd = 1'b1;
        @(negedge clk);
        uart_txd = 1'b0;
        #1;
        check("R5 before edge", tx_pin, 1'b1);
        @(negedge clk);
        check("R5 after edge", tx_pin, 1'b0);

        // R3 R4: modulated zeros, each duty code over two periods.
        cfg_mod_en = 1'b1;
        for (int d = 0; d < 4; d++) begin
            cfg_duty = 2'(d);
            repeat (2) @(negedge clk);
            count_low(lows);
            check_int($sformatf("R4 duty %0d low clocks", d), lows, 2 * DIV * (8 >> d));
        end

        // R3: modulated ones stay high.
        uart_txd = 1'b1;
        cfg_duty = 2'd0;
        repeat (2) @(negedge clk);
        count_low(lows);
        check_int("R3 mark unmodulated", lows, 0);

        // R2: inverted one becomes zero, which then carries the 50% carrier.
        cfg_tx_inv = 1'b1;
        repeat (2) @(negedge clk);
        count_low(lows);
        check_int("R2 invert before carrier", lows, 2 * DIV * 8);

        // R9: a low general-purpose bit is not touched by carrier or inversion.
        cfg_tx_src = 2'd1;
        gpo_bit = 1'b0;
        repeat (2) @(negedge clk);
        count_low(lows);
        check_int("R9 gpo unmodulated", lows, 2 * PERIOD);

        // R9: a high pulse stream passes unaltered with modulation on.
        cfg_tx_src = 2'd2;
        wpulse = 1'b1;
        repeat (2) @(negedge clk);
        count_low(lows);
        check_int("R9 wpulse unmodulated", lows, 0);

        // R8: reset in mid-run restores idle high.
        cfg_tx_src = 2'd0;
        cfg_tx_inv = 1'b0;
        uart_txd = 1'b0;
        cfg_mod_en = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R8 reset mid-run", tx_pin, 1'b1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule